// File: doc/BRIEF.md
# Byte-Lane Addressed Memory Slave

This block is a synchronous RAM that sits on a 32-bit processor memory bus. In each cycle it can take a request made of a byte address, a direction bit and a two-bit transfer-size code. A write is split into four independent byte write enables, so a byte, a halfword or a full word can be stored without disturbing the neighbouring bytes. A read returns the whole aligned 32-bit word one cycle later, and the requester picks out the lane it needs. Address bits that are redundant for the signalled size never affect which bytes are touched. This matters because instruction fetches may leave those bits undefined.

A sequential-cycle input tells the slave to ignore the address bus and continue from an internal address. That address advances by the transfer size after every accepted request, which lets a burst run without the requester supplying each address. Lane mapping is little-endian. For narrow writes, the write data is expected to be replicated across the lanes, and each lane takes the byte at its own position on the data bus. The depth in words is a parameter, and address bits above the word index wrap.

Top module: `lane_ram`

## Requirements
- R1: While reset is held and after it is released, `rdata` reads 0 and `size_err` reads 0 until the first request is accepted.
- R2: `wr`=1 marks a write and `wr`=0 marks a read. A read never changes memory contents. `rdata` keeps its value through write cycles.
- R3: A byte write (size 00) updates only lane `addr[1:0]`, where lane k is bits 8k+7:8k of the word. Lane k takes its byte from `wdata[8k+7:8k]`.
- R4: A halfword write (size 01) updates lanes {addr[1],0} and {addr[1],1} from their own `wdata` positions. `addr[0]` is ignored.
- R5: A word write (size 10) updates all four lanes. `addr[1:0]` is ignored.
- R6: A read returns, in the cycle after the request, the full 32-bit word at word index `addr[IDX_W+1:2]`, for every size code and every value of `addr[1:0]`.
- R7: The reserved size code 11 writes nothing. It drives `size_err` high in the cycle after the request, and `size_err` is low after any cycle that carried no reserved request.
- R8: When `seq`=1, the `addr` input is ignored. The effective address is the previous effective address plus 1, 2 or 4 bytes for size 00, 01 or 10 respectively.
- R9: Address bits above the word index are ignored, so addresses that differ by a multiple of 4*DEPTH select the same word.
- R10: While `req`=0, nothing is written and `rdata` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | A transfer is presented this cycle |
| wr | input | 1 | 1 = write, 0 = read |
| size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| seq | input | 1 | Sequential cycle: use the internal incremented address |
| addr | input | 32 | Byte address |
| wdata | input | 32 | Write data, replicated across lanes for narrow writes |
| rdata | output | 32 | Aligned read word, valid the cycle after a read |
| size_err | output | 1 | Reserved size code seen on the previous cycle |

## Verification
A wrong byte strobe does not show when the write happens. It surfaces on the next word read of that address, as a corrupted or stale lane, so the bench always follows writes with full-word reads of the words they touched. A drifting burst address shows up one transfer later, when the data lands in the neighbouring lane or word. A stuck error flag or an `rdata` register that fails to hold is visible in the cycle right after the offending request.

// File: rtl/lane_ram_pkg.sv
package lane_ram_pkg;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;
  localparam logic [1:0] SZ_RSVD = 2'b11;

  // Little-endian lane strobes for a transfer of size sz at byte offset lo.
  function automatic logic [3:0] lane_mask(input logic [1:0] sz, input logic [1:0] lo);
    logic [3:0] m;
    case (sz)
      SZ_BYTE: m = 4'b0001 << lo;
      SZ_HALF: m = lo[1] ? 4'b1100 : 4'b0011;
      SZ_WORD: m = 4'b1111;
      default: m = 4'b0000;
    endcase
    return m;
  endfunction

  // Bytes covered by one transfer; reserved code does not advance.
  function automatic logic [2:0] step_bytes(input logic [1:0] sz);
    logic [2:0] s;
    case (sz)
      SZ_BYTE: s = 3'd1;
      SZ_HALF: s = 3'd2;
      SZ_WORD: s = 3'd4;
      default: s = 3'd0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/lane_decode.sv
module lane_decode
  import lane_ram_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic       wr,
  input  logic [1:0] size,
  input  logic [1:0] lo,
  output logic [3:0] we,
  output logic       rsvd
);

  logic wr_cycle;
  assign wr_cycle = req && wr;
  assign we   = wr_cycle ? lane_mask(size, lo) : 4'b0000;
  assign rsvd = req && (size == SZ_RSVD);

  a_r3_byte_single: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cycle && size == SZ_BYTE) |-> ($countones(we) == 1));

  a_r4_half_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cycle && size == SZ_HALF) |-> (we == 4'b0011 || we == 4'b1100));

  a_r5_word_all: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cycle && size == SZ_WORD) |-> (we == 4'b1111));

  a_r7_rsvd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd |-> (we == 4'b0000));

  a_r2_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr || !req) |-> (we == 4'b0000));

endmodule

// File: rtl/burst_addr.sv
module burst_addr
  import lane_ram_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        seq,
  input  logic [1:0]  size,
  input  logic [31:0] addr,
  output logic [31:0] eff
);

  logic [31:0] next_q;
  logic [31:0] step_w;

  assign step_w = {29'd0, step_bytes(size)};
  assign eff    = seq ? next_q : addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   next_q <= '0;
    else if (req) next_q <= eff + step_w;
  end

  a_r8_seq_follow: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> (!(req && seq) || eff == $past(eff) + $past(step_w)));

endmodule

// File: rtl/lane_bank.sv
module lane_bank #(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       we,
  input  logic             rd,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);

  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we[l]) mem[idx] <= wdata[8*l +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata[8*l +: 8] <= 8'h00;
      else if (rd) rdata[8*l +: 8] <= mem[idx];
    end
  end

endmodule

// File: rtl/lane_ram.sv
module lane_ram #(
  parameter int DEPTH = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        wr,
  input  logic [1:0]  size,
  input  logic        seq,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        size_err
);

  localparam int IDX_W = $clog2(DEPTH);

  logic [31:0]      eff_addr;
  logic [3:0]       lane_we;
  logic             rsvd_hit;
  logic             rd_cycle;
  logic [IDX_W-1:0] word_idx;

  assign rd_cycle = req && !wr;
  assign word_idx = eff_addr[IDX_W+1:2];

  burst_addr u_addr (
    .clk(clk), .rst_n(rst_n), .req(req), .seq(seq),
    .size(size), .addr(addr), .eff(eff_addr)
  );

  lane_decode u_dec (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .size(size),
    .lo(eff_addr[1:0]), .we(lane_we), .rsvd(rsvd_hit)
  );

  lane_bank #(.DEPTH(DEPTH)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(lane_we), .rd(rd_cycle),
    .idx(word_idx), .wdata(wdata), .rdata(rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) size_err <= 1'b0;
    else        size_err <= rsvd_hit;
  end

  a_r7_err_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (req && size == 2'b11) |=> size_err);

  a_r7_err_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && size == 2'b11) |=> !size_err);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> $stable(rdata));

  a_r2_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req && wr) |=> $stable(rdata));

endmodule

// File: tb/lane_ram_test.sv
`timescale 1ns/1ps
module lane_ram_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0, seq = 1'b0;
  logic [1:0]  size = 2'b00;
  logic [31:0] addr = '0, wdata = '0;
  logic [31:0] rdata;
  logic        size_err;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lane_ram #(.DEPTH(256)) uut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .size(size), .seq(seq),
    .addr(addr), .wdata(wdata), .rdata(rdata), .size_err(size_err)
  );

  // {wr, size, addr[15:0], wdata, check_rdata, exp_rdata, exp_err}
  localparam int NV = 10;
  localparam logic [84:0] VEC [NV] = '{
    {1'b1, 2'b10, 16'h0010, 32'h11223344, 1'b0, 32'h0,        1'b0}, // R5 word
    {1'b1, 2'b00, 16'h0011, 32'hAAAAAAAA, 1'b0, 32'h0,        1'b0}, // R3 lane1
    {1'b1, 2'b01, 16'h0013, 32'hBEEFBEEF, 1'b0, 32'h0,        1'b0}, // R4 bit0 ignored
    {1'b0, 2'b10, 16'h0012, 32'h0,        1'b1, 32'hBEEFAA44, 1'b0}, // R6
    {1'b1, 2'b10, 16'h0023, 32'hCAFEF00D, 1'b0, 32'h0,        1'b0}, // R5 low bits ignored
    {1'b0, 2'b00, 16'h0021, 32'h0,        1'b1, 32'hCAFEF00D, 1'b0}, // R6 byte read
    {1'b1, 2'b11, 16'h0020, 32'h0,        1'b0, 32'h0,        1'b1}, // R7 reserved
    {1'b0, 2'b01, 16'h0020, 32'h0,        1'b1, 32'hCAFEF00D, 1'b0}, // R7 no write
    {1'b1, 2'b01, 16'h0010, 32'h55665566, 1'b0, 32'h0,        1'b0}, // R4 low lanes
    {1'b0, 2'b10, 16'h0010, 32'h0,        1'b1, 32'hBEEF5566, 1'b0}  // R4/R6
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic r, input logic w, input logic [1:0] sz,
                      input logic [31:0] a, input logic [31:0] d, input logic sq);
    req = r; wr = w; size = sz; addr = a; wdata = d; seq = sq;
    @(posedge clk); #1;
    req = 1'b0; seq = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 rdata in reset", rdata, 32'h0);
    check("R1 size_err in reset", {31'd0, size_err}, 32'h0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 rdata after reset", rdata, 32'h0);
    check("R1 size_err after reset", {31'd0, size_err}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      xfer(1'b1, VEC[i][84], VEC[i][83:82], {16'h0, VEC[i][81:66]}, VEC[i][65:34], 1'b0);
      if (VEC[i][33]) check($sformatf("R6 vector %0d rdata", i), rdata, VEC[i][32:1]);
      check($sformatf("R7 vector %0d size_err", i), {31'd0, size_err}, {31'd0, VEC[i][0]});
    end

    // R2: read with junk write data leaves memory alone; write holds rdata
    xfer(1'b1, 1'b0, 2'b10, 32'h10, 32'hFFFFFFFF, 1'b0);
    xfer(1'b1, 1'b1, 2'b10, 32'h30, 32'h0BADF00D, 1'b0);
    check("R2 rdata held on write", rdata, 32'hBEEF5566);
    xfer(1'b1, 1'b0, 2'b10, 32'h10, 32'h0, 1'b0);
    check("R2 read did not write", rdata, 32'hBEEF5566);

    // R8: word burst, addr input is garbage on the sequential cycle
    xfer(1'b1, 1'b1, 2'b10, 32'h40, 32'hA0A0A0A0, 1'b0);
    xfer(1'b1, 1'b1, 2'b10, 32'hFFFF, 32'hB1B1B1B1, 1'b1);
    xfer(1'b1, 1'b0, 2'b10, 32'h44, 32'h0, 1'b0);
    check("R8 word burst second beat", rdata, 32'hB1B1B1B1);
    xfer(1'b1, 1'b0, 2'b10, 32'h40, 32'h0, 1'b0);
    check("R8 word burst first beat", rdata, 32'hA0A0A0A0);
    xfer(1'b1, 1'b0, 2'b10, 32'h0, 32'h0, 1'b1);
    check("R8 sequential read", rdata, 32'hB1B1B1B1);

    // R8: halfword burst steps by two bytes
    xfer(1'b1, 1'b1, 2'b01, 32'h50, 32'h11111111, 1'b0);
    xfer(1'b1, 1'b1, 2'b01, 32'h9C, 32'h22222222, 1'b1);
    xfer(1'b1, 1'b0, 2'b10, 32'h50, 32'h0, 1'b0);
    check("R8 halfword burst lanes", rdata, 32'h22221111);

    // R8 + R3: byte burst fills lanes one by one
    xfer(1'b1, 1'b1, 2'b00, 32'h60, 32'h01010101, 1'b0);
    xfer(1'b1, 1'b1, 2'b00, 32'h0, 32'h02020202, 1'b1);
    xfer(1'b1, 1'b1, 2'b00, 32'h0, 32'h03030303, 1'b1);
    xfer(1'b1, 1'b1, 2'b00, 32'h0, 32'h04040404, 1'b1);
    xfer(1'b1, 1'b0, 2'b10, 32'h60, 32'h0, 1'b0);
    check("R3 byte burst lanes", rdata, 32'h04030201);

    // R9: alias at 4*DEPTH bytes above
    xfer(1'b1, 1'b1, 2'b10, 32'h0000_0400 + 32'h70, 32'hC0DEC0DE, 1'b0);
    xfer(1'b1, 1'b0, 2'b10, 32'h70, 32'h0, 1'b0);
    check("R9 alias read", rdata, 32'hC0DEC0DE);

    // R10: idle with write-like inputs changes nothing
    req = 1'b0; wr = 1'b1; size = 2'b10; addr = 32'h70; wdata = 32'hDEADDEAD;
    @(posedge clk); #1;
    @(posedge clk); #1;
    check("R10 rdata held while idle", rdata, 32'hC0DEC0DE);
    check("R10 no error while idle", {31'd0, size_err}, 32'h0);
    xfer(1'b1, 1'b0, 2'b10, 32'h70, 32'h0, 1'b0);
    check("R10 idle did not write", rdata, 32'hC0DEC0DE);

    // R7: reserved read still flags, then clears
    xfer(1'b1, 1'b0, 2'b11, 32'h70, 32'h0, 1'b0);
    check("R7 reserved read flag", {31'd0, size_err}, 32'h1);
    xfer(1'b1, 1'b0, 2'b10, 32'h70, 32'h0, 1'b0);
    check("R7 flag cleared", {31'd0, size_err}, 32'h0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule